// File: doc/BRIEF.md
# Prioritized Transmit Queue Scheduler

This block decides, every clock cycle, which of sixteen transmit descriptor rings sends its head descriptor next. It then issues that descriptor to one of eight DMA channels. Each ring has an 8-bit status word. The word binds the ring to one channel, marks it active or idle, and selects its mode. Any number of rings may share a channel. Channel index is priority: 0 background, 1 best effort, 2 video, 3 voice and management, 4 to 6 spare, and 7 commands, which is the highest. A grant goes to the highest-indexed channel that has a ready, eligible ring. Among the rings bound to that channel, grants rotate round-robin.

A ring in aggregation mode gives up its head descriptor as soon as the descriptor is issued, so it can issue back to back. A ring in in-order mode keeps a single frame in flight. On a failure report it reissues that same head frame, flagged as a retry. On an ack it releases the head. When a failure arrives after the programmed number of retries, it drops the frame and sets a sticky error flag for that ring. Any ring bound to the command channel always behaves in in-order mode.

The surrounding logic keeps the ring pointers. It advances a ring on each `q_pop_o` pulse, and it reports the ack or failure of in-order frames through the feedback port.

Top module: `txq_sched`

## Requirements
- R1: While reset is held, and after it until a ring is made active, `issue_valid_o` stays 0. `q_pop_o` and `q_err_o` are also 0.
- R2: A ring whose status word has bit 3 (active) at 0 is never granted, even when it is non-empty.
- R3: Status word writes use `cfg_addr_i` equal to the ring index. Bits 2:0 are the channel, bit 3 is active and bit 4 is aggregation mode (1) or in-order mode (0). A grant reports on `issue_ch_o` the channel held in the granted ring's word. It reports that ring's head on `issue_desc_o`.
- R4: When several channels have eligible rings, the grant goes to the highest channel index.
- R5: A channel whose `ch_ready_i` bit is 0 receives no grant. The next lower channel is served instead.
- R6: Rings bound to the same channel are granted in rotating order. The search starts at the ring index after the channel's last grant and wraps around.
- R7: An aggregation ring pulses its `q_pop_o` bit in the same cycle as its grant, and it can be granted in consecutive cycles.
- R8: An in-order ring is not popped at grant. After a grant it is not granted again until feedback arrives. On ack feedback it pulses `q_pop_o` in the feedback cycle, and its next grant has `issue_retry_o` at 0.
- R9: Failure feedback (`fb_ack_i`=0) on an in-order ring in flight causes a regrant of the same ring in the next cycle, with `issue_retry_o`=1.
- R10: The retry limit is written at address 16, bits 3:0. A failure that arrives after that many retries pulses the ring's `q_pop_o` in the same cycle. The ring's `q_err_o` bit goes to 1 from the next cycle and holds.
- R11: Writing a ring's status word clears that ring's error flag.
- R12: A ring bound to channel 7 behaves as in-order even when its aggregation bit is 1.
- R13: Feedback for a ring that has no frame in flight, or that is in aggregation mode, causes no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | 0..15 ring status word, 16 retry limit |
| cfg_wdata_i | input | 8 | Configuration write data |
| q_nonempty_i | input | 16 | Per-ring descriptor available |
| q_head_i | input | 256 | Per-ring head descriptor, 16 bits each, ring n at bits 16n+15:16n |
| ch_ready_i | input | 8 | Per-channel space available |
| fb_valid_i | input | 1 | Transmit feedback valid |
| fb_q_i | input | 4 | Ring the feedback refers to |
| fb_ack_i | input | 1 | 1 acked, 0 attempt failed |
| issue_valid_o | output | 1 | A descriptor is issued this cycle |
| issue_q_o | output | 4 | Granted ring |
| issue_ch_o | output | 3 | Destination channel |
| issue_desc_o | output | 16 | Issued head descriptor |
| issue_retry_o | output | 1 | Issue is a retransmission |
| q_pop_o | output | 16 | Per-ring head consumed |
| q_err_o | output | 16 | Per-ring sticky drop flag |

## Verification
Every cycle, the assertions check these things about a grant: the granted ring is active and non-empty, its channel is ready, and the reported channel matches the ring's word. They also check that an aggregation grant pops, that an in-order grant is never repeated in the next cycle, and that an error flag falls only after a configuration write. Some behaviour depends on history, and only the bench scenarios show it. This covers the order of the round-robin rotation, priority between channels, retry counting up to the programmed limit with the drop that follows, forcing of the command channel to in-order mode, and feedback being ignored when no frame is in flight.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
  localparam int CH_FW    = 3;
  localparam int NUM_CH   = 1 << CH_FW;
  localparam int CMD_CH   = NUM_CH - 1;
  localparam int STAT_ACT = 3;
  localparam int STAT_AGG = 4;

  typedef struct packed {
    logic             agg;
    logic             active;
    logic [CH_FW-1:0] ch;
  } q_stat_t;
endpackage

// File: rtl/txq_cfg_regs.sv
module txq_cfg_regs
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q   = 16,
  parameter int RETRY_W = 4,
  localparam int QW     = $clog2(NUM_Q)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [QW:0]        addr_i,
  input  logic [7:0]         wdata_i,
  output q_stat_t            stat_o [NUM_Q],
  output logic [NUM_Q-1:0]   wr_q_o,
  output logic [RETRY_W-1:0] retry_lim_o
);
  localparam logic [RETRY_W-1:0] LIM_RST = RETRY_W'(3);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    localparam logic [CH_FW-1:0] DEF_CH = (g < CMD_CH) ? CH_FW'(g) : '0;
    assign wr_q_o[g] = we_i && (addr_i == (QW+1)'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_o[g] <= '{agg: 1'b0, active: 1'b0, ch: DEF_CH};
      end else if (wr_q_o[g]) begin
        stat_o[g] <= '{agg: wdata_i[STAT_AGG], active: wdata_i[STAT_ACT],
                       ch: wdata_i[CH_FW-1:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) retry_lim_o <= LIM_RST;
    else if (we_i && addr_i == (QW+1)'(NUM_Q)) retry_lim_o <= wdata_i[RETRY_W-1:0];
  end
endmodule

// File: rtl/txq_fifo_ctl.sv
module txq_fifo_ctl #(
  parameter int RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_mode_i,
  input  logic               grant_i,
  input  logic               fb_hit_i,
  input  logic               fb_ack_i,
  input  logic [RETRY_W-1:0] lim_i,
  input  logic               clr_err_i,
  output logic               busy_o,
  output logic               pop_o,
  output logic               retry_o,
  output logic               err_o
);
  logic               inflight, pend;
  logic [RETRY_W-1:0] cnt;
  logic               take_fb, exhausted, drop;

  // feedback only counts while a frame waits for its result
  assign take_fb   = fb_hit_i && fifo_mode_i && inflight && !pend;
  assign exhausted = (cnt == lim_i);
  assign drop      = take_fb && !fb_ack_i && exhausted;
  assign pop_o     = take_fb && (fb_ack_i || exhausted);
  assign busy_o    = inflight && !pend;
  assign retry_o   = (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
    end else if (take_fb) begin
      if (pop_o) begin
        inflight <= 1'b0;
        pend     <= 1'b0;
        cnt      <= '0;
      end else begin
        pend <= 1'b1;
        cnt  <= cnt + 1'b1;
      end
    end else if (grant_i && fifo_mode_i) begin
      inflight <= 1'b1;
      pend     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (drop)      err_o <= 1'b1;
    else if (clr_err_i) err_o <= 1'b0;
  end
endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW   = $clog2(NUM_Q)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_Q-1:0]       elig_i,
  input  logic [NUM_Q*CH_FW-1:0] q_chan_i,
  output logic                   grant_o,
  output logic [QW-1:0]          grant_q_o,
  output logic [CH_FW-1:0]       grant_ch_o
);
  logic [NUM_CH-1:0] ch_has;
  logic [QW-1:0]     rr_ptr [NUM_CH];

  always_comb begin
    ch_has = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (elig_i[q] && q_chan_i[q*CH_FW +: CH_FW] == CH_FW'(c)) ch_has[c] = 1'b1;
      end
    end
  end

  // highest channel index wins
  always_comb begin
    grant_ch_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_has[c]) grant_ch_o = CH_FW'(c);
    end
  end

  assign grant_o = |ch_has;

  // rotate from the ring after the channel's last grant
  always_comb begin
    logic          hit;
    logic [QW-1:0] idx;
    hit       = 1'b0;
    grant_q_o = '0;
    for (int i = 1; i <= NUM_Q; i++) begin
      idx = rr_ptr[grant_ch_o] + QW'(i);
      if (!hit && elig_i[idx] && q_chan_i[idx*CH_FW +: CH_FW] == grant_ch_o) begin
        hit       = 1'b1;
        grant_q_o = idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++) rr_ptr[c] <= '0;
    end else if (grant_o) begin
      rr_ptr[grant_ch_o] <= grant_q_o;
    end
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q   = 16,
  parameter int DESC_W  = 16,
  parameter int RETRY_W = 4,
  localparam int QW     = $clog2(NUM_Q)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [QW:0]             cfg_addr_i,
  input  logic [7:0]              cfg_wdata_i,
  input  logic [NUM_Q-1:0]        q_nonempty_i,
  input  logic [NUM_Q*DESC_W-1:0] q_head_i,
  input  logic [NUM_CH-1:0]       ch_ready_i,
  input  logic                    fb_valid_i,
  input  logic [QW-1:0]           fb_q_i,
  input  logic                    fb_ack_i,
  output logic                    issue_valid_o,
  output logic [QW-1:0]           issue_q_o,
  output logic [CH_FW-1:0]        issue_ch_o,
  output logic [DESC_W-1:0]       issue_desc_o,
  output logic                    issue_retry_o,
  output logic [NUM_Q-1:0]        q_pop_o,
  output logic [NUM_Q-1:0]        q_err_o
);
  q_stat_t                stat [NUM_Q];
  logic [NUM_Q-1:0]       wr_q;
  logic [RETRY_W-1:0]     retry_lim;
  logic [NUM_Q-1:0]       q_active, q_fifo, busy, pop_fb, retry, elig;
  logic [NUM_Q*CH_FW-1:0] q_chan_flat;

  txq_cfg_regs #(.NUM_Q(NUM_Q), .RETRY_W(RETRY_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .stat_o      (stat),
    .wr_q_o      (wr_q),
    .retry_lim_o (retry_lim)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign q_active[g] = stat[g].active;
    assign q_chan_flat[g*CH_FW +: CH_FW] = stat[g].ch;
    // command channel is always in-order
    assign q_fifo[g] = !stat[g].agg || (stat[g].ch == CH_FW'(CMD_CH));
    assign elig[g]   = stat[g].active && q_nonempty_i[g] &&
                       ch_ready_i[stat[g].ch] && !busy[g];

    txq_fifo_ctl #(.RETRY_W(RETRY_W)) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fifo_mode_i (q_fifo[g]),
      .grant_i     (issue_valid_o && issue_q_o == QW'(g)),
      .fb_hit_i    (fb_valid_i && fb_q_i == QW'(g)),
      .fb_ack_i    (fb_ack_i),
      .lim_i       (retry_lim),
      .clr_err_i   (wr_q[g]),
      .busy_o      (busy[g]),
      .pop_o       (pop_fb[g]),
      .retry_o     (retry[g]),
      .err_o       (q_err_o[g])
    );

    assign q_pop_o[g] = pop_fb[g] ||
                        (issue_valid_o && issue_q_o == QW'(g) && !q_fifo[g]);
  end

  txq_arbiter #(.NUM_Q(NUM_Q)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .elig_i     (elig),
    .q_chan_i   (q_chan_flat),
    .grant_o    (issue_valid_o),
    .grant_q_o  (issue_q_o),
    .grant_ch_o (issue_ch_o)
  );

  assign issue_desc_o  = q_head_i[issue_q_o*DESC_W +: DESC_W];
  assign issue_retry_o = retry[issue_q_o];
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW   = $clog2(NUM_Q)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_we_i,
  input logic [NUM_Q-1:0]       q_nonempty_i,
  input logic [NUM_CH-1:0]      ch_ready_i,
  input logic                   issue_valid_o,
  input logic [QW-1:0]          issue_q_o,
  input logic [CH_FW-1:0]       issue_ch_o,
  input logic [NUM_Q-1:0]       q_pop_o,
  input logic [NUM_Q-1:0]       q_err_o,
  input logic [NUM_Q-1:0]       q_active,
  input logic [NUM_Q-1:0]       q_fifo,
  input logic [NUM_Q*CH_FW-1:0] q_chan
);
  p_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (q_active[issue_q_o] && q_nonempty_i[issue_q_o]));

  p_chan_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (issue_ch_o == q_chan[issue_q_o*CH_FW +: CH_FW]));

  p_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ch_ready_i[issue_ch_o]);

  p_agg_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !q_fifo[issue_q_o]) |-> q_pop_o[issue_q_o]);

  p_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && q_fifo[issue_q_o] && !cfg_we_i)
      |=> !(issue_valid_o && issue_q_o == $past(issue_q_o)));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(q_err_o) & ~q_err_o)) |-> $past(cfg_we_i));
endmodule

bind txq_sched txq_sched_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .q_nonempty_i  (q_nonempty_i),
  .ch_ready_i    (ch_ready_i),
  .issue_valid_o (issue_valid_o),
  .issue_q_o     (issue_q_o),
  .issue_ch_o    (issue_ch_o),
  .q_pop_o       (q_pop_o),
  .q_err_o       (q_err_o),
  .q_active      (q_active),
  .q_fifo        (q_fifo),
  .q_chan        (q_chan_flat)
);

// File: tb/txq_sched_bench.sv
module txq_sched_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [4:0]   cfg_addr;
  logic [7:0]   cfg_wdata;
  logic [15:0]  nonempty;
  logic [255:0] head;
  logic [7:0]   ch_rdy;
  logic         fb_valid;
  logic [3:0]   fb_q;
  logic         fb_ack;
  logic         issue_valid;
  logic [3:0]   issue_q;
  logic [2:0]   issue_ch;
  logic [15:0]  issue_desc;
  logic         issue_retry;
  logic [15:0]  q_pop;
  logic [15:0]  q_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  txq_sched u_txq_sched (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .q_nonempty_i(nonempty), .q_head_i(head),
    .ch_ready_i(ch_rdy), .fb_valid_i(fb_valid), .fb_q_i(fb_q), .fb_ack_i(fb_ack),
    .issue_valid_o(issue_valid), .issue_q_o(issue_q), .issue_ch_o(issue_ch),
    .issue_desc_o(issue_desc), .issue_retry_o(issue_retry), .q_pop_o(q_pop),
    .q_err_o(q_err)
  );

  function automatic logic [15:0] desc_of(int q);
    return 16'hC000 + 16'(q) * 16'h0101;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_issue(int q, int ch, bit rt, string tag);
    exp_q.push_back({q[3:0], ch[2:0], rt});
    exp_tag.push_back(tag);
  endtask

  task automatic nxt();
    @(negedge clk);
    cfg_we   = 1'b0;
    fb_valid = 1'b0;
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic wr(int a, int d);
    nxt();
    cfg_we    = 1'b1;
    cfg_addr  = a[4:0];
    cfg_wdata = d[7:0];
    settle();
  endtask

  task automatic fb(int q, bit ack);
    fb_valid = 1'b1;
    fb_q     = q[3:0];
    fb_ack   = ack;
  endtask

  // monitor: compare each issue against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n === 1'b1) begin
        if (issue_valid === 1'b1) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL unexpected issue: actual q%0d expected none", issue_q);
          end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk({t, " ring"},    32'(issue_q),     32'(e[7:4]));
            chk({t, " channel"}, 32'(issue_ch),    32'(e[3:1]));
            chk({t, " retry"},   32'(issue_retry), 32'(e[0]));
            chk({t, " desc"},    32'(issue_desc),  32'(desc_of(int'(e[7:4]))));
          end
        end else if (exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          checks++; errors++;
          $display("FAIL %s missed issue: actual none expected issue", exp_tag.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; nonempty = 0;
    ch_rdy = 8'hFF; fb_valid = 0; fb_q = 0; fb_ack = 0;
    for (int q = 0; q < 16; q++) head[q*16 +: 16] = desc_of(q);
    repeat (3) @(negedge clk);
    settle();
    chk("R1 valid in reset", 32'(issue_valid), 0);
    chk("R1 err in reset", 32'(q_err), 0);
    nxt(); rst_n = 1'b1;
    nxt(); nonempty = 16'hFFFF; settle();
    chk("R1 idle valid", 32'(issue_valid), 0);
    chk("R1 idle pop", 32'(q_pop), 0);
    nxt(); nonempty = 0;

    // R7 aggregation ring 2 on channel 2
    wr(2, 8'h1A);
    nxt(); nonempty = 16'h0004; exp_issue(2, 2, 0, "R7"); settle();
    chk("R7 pop", 32'(q_pop), 32'h0004);
    nxt(); exp_issue(2, 2, 0, "R7"); settle();
    chk("R7 pop b2b", 32'(q_pop), 32'h0004);

    // R4 / R5 priority and ready
    nxt(); nonempty = 0;
    wr(5, 8'h19);
    wr(9, 8'h1B);
    nxt(); nonempty = 16'h0224; exp_issue(9, 3, 0, "R4"); settle();
    nxt(); ch_rdy = 8'hF7; exp_issue(2, 2, 0, "R5"); settle();
    nxt(); ch_rdy = 8'hF3; exp_issue(5, 1, 0, "R3"); settle();
    nxt(); ch_rdy = 8'hF1; settle();
    chk("R5 none ready", 32'(issue_valid), 0);
    nxt(); ch_rdy = 8'hFF; nonempty = 0;

    // R6 round robin on channel 3
    wr(10, 8'h1B);
    wr(12, 8'h1B);
    nxt(); nonempty = 16'h1600; exp_issue(10, 3, 0, "R6"); settle();
    nxt(); exp_issue(12, 3, 0, "R6"); settle();
    nxt(); exp_issue(9, 3, 0, "R6"); settle();
    nxt(); exp_issue(10, 3, 0, "R6"); settle();
    nxt(); nonempty = 0;

    // R2 inactive ring
    wr(9, 8'h13);
    nxt(); nonempty = 16'h0200; settle();
    chk("R2 inactive", 32'(issue_valid), 0);
    nxt(); settle();
    chk("R2 inactive hold", 32'(issue_valid), 0);
    nxt(); nonempty = 0;

    // R8 / R9 / R10 in-order ring 4, limit 2
    wr(16, 2);
    wr(4, 8'h08);
    nxt(); nonempty = 16'h0010; exp_issue(4, 0, 0, "R8"); settle();
    chk("R8 no pop at grant", 32'(q_pop), 0);
    nxt(); settle();
    chk("R8 single in flight", 32'(issue_valid), 0);
    nxt(); fb(4, 0); settle();
    chk("R9 fail cycle no issue", 32'(issue_valid), 0);
    chk("R9 fail cycle no pop", 32'(q_pop), 0);
    nxt(); exp_issue(4, 0, 1, "R9"); settle();
    nxt(); fb(4, 1); settle();
    chk("R8 ack pop", 32'(q_pop), 32'h0010);
    nxt(); exp_issue(4, 0, 0, "R8"); settle();
    nxt(); fb(4, 0); settle();
    nxt(); exp_issue(4, 0, 1, "R10"); settle();
    nxt(); fb(4, 0); settle();
    nxt(); exp_issue(4, 0, 1, "R10"); settle();
    nxt(); fb(4, 0); settle();
    chk("R10 drop pop", 32'(q_pop), 32'h0010);
    chk("R10 err before edge", 32'(q_err), 0);
    nxt(); nonempty = 0; settle();
    chk("R10 err set", 32'(q_err), 32'h0010);
    nxt(); settle();
    chk("R10 err sticky", 32'(q_err), 32'h0010);

    // R11 clear by status write
    wr(4, 8'h08);
    nxt(); settle();
    chk("R11 err cleared", 32'(q_err), 0);

    // R13 stray feedback
    nxt(); fb(4, 1); settle();
    chk("R13 idle ring fb", 32'(q_pop), 0);
    nxt(); fb(2, 1); settle();
    chk("R13 agg ring fb", 32'(q_pop), 0);

    // R12 command channel forced in-order
    wr(7, 8'h1F);
    nxt(); nonempty = 16'h0080; exp_issue(7, 7, 0, "R12"); settle();
    chk("R12 no pop at grant", 32'(q_pop), 0);
    nxt(); settle();
    chk("R12 held", 32'(issue_valid), 0);
    nxt(); fb(7, 1); settle();
    chk("R12 ack pop", 32'(q_pop), 32'h0080);
    nxt(); nonempty = 0;
    repeat (3) nxt();
    settle();
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule